// File: doc/BRIEF.md
# Bit-Serial Adder With Stored Carry

This block adds two WIDTH-bit unsigned operands one bit position per clock, using a single full adder. Each operand sits in its own register that moves one place toward the least significant end on every enabled step. The two low bits and the stored carry feed the full adder. The sum bit enters the top of the accumulator register, so after the last step the accumulator holds the sum in the place where operand A was loaded. One flip-flop carries the carry from one bit position to the next.

A `start` pulse loads both operands in parallel and clears the carry. The run then advances only on cycles where `shift_en` is high. The second operand register takes an external serial bit at its top end on each step, so the next operand can be streamed in while the current addition runs. After exactly WIDTH enabled steps the run stops, `done_o` pulses for one cycle and `ovf_o` holds the final carry-out.

Top module: `bitser_add`

## Requirements
- R1: While reset is asserted and after it is released, `acc_o`, `opb_o`, `ovf_o`, `busy_o` and `done_o` are all zero.
- R2: A cycle with `start` high loads `a_load` into `acc_o` and `b_load` into `opb_o`, clears `ovf_o` to 0, raises `busy_o` and restarts the step count, all at the next clock edge.
- R3: `start` takes priority over `shift_en`. When both are high, the load happens and no step is taken, even in the middle of a run.
- R4: On each step (`busy_o` and `shift_en` high, `start` low), `acc_o` moves right by one bit and its bit WIDTH-1 receives the XOR of the old `acc_o[0]`, `opb_o[0]` and `ovf_o`.
- R5: On each step, `ovf_o` takes the majority of the old `acc_o[0]`, `opb_o[0]` and `ovf_o`, and that value is the carry-in for the next step.
- R6: On each step, `opb_o` moves right by one bit and its bit WIDTH-1 receives `b_ser_in`.
- R7: After exactly WIDTH steps, `busy_o` falls, `acc_o` equals (A + B) mod 2^WIDTH, and `done_o` is high for exactly one cycle, the cycle after the final step edge.
- R8: When the run ends, `ovf_o` equals bit WIDTH of A + B and holds that value until the next `start`.
- R9: During a run, a cycle with `shift_en` low leaves `acc_o`, `opb_o`, `ovf_o` and the step count unchanged.
- R10: While idle (`busy_o` low), `shift_en` and `b_ser_in` have no effect on any output.
- R11: With WIDTH=8, A=4 and B=7, the low sum bits produced over the first four steps are 1, 1, 0 (carry 1), 1. The run ends with `acc_o`=11 and `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load both operands and clear the carry |
| shift_en | input | 1 | Take one serial step while busy |
| a_load | input | WIDTH | Parallel value for operand A / accumulator |
| b_load | input | WIDTH | Parallel value for operand B |
| b_ser_in | input | 1 | Serial bit entering the top of operand B on each step |
| acc_o | output | WIDTH | Accumulator contents (operand A, then partial and final sum) |
| opb_o | output | WIDTH | Operand B register contents |
| ovf_o | output | 1 | Stored carry; the final carry-out once the run ends |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the final step |

## Verification
A wrong sum or carry bit appears at the top of `acc_o` on the edge of the step that produced it. It then moves down one place per step until it reaches bit 0, so a single bad bit corrupts the final sum and `ovf_o`. An off-by-one in the step count shows up as `busy_o` and `done_o` arriving one cycle early or late. It also leaves the accumulator rotated by one place, which the final value exposes. The reference model is compared with every output on every cycle, so any divergence is reported in the cycle it first becomes visible, not only at the end of the run.

// File: rtl/bitser_add_pkg.sv
package bitser_add_pkg;

  function automatic logic fa_sum(input logic x, input logic y, input logic cin);
    return x ^ y ^ cin;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic cin);
    return (x & y) | (x & cin) | (y & cin);
  endfunction

endpackage

// File: rtl/bitser_shreg.sv
module bitser_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] upper;
  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH-1) begin : g_top
      assign upper[i] = ser_in;
    end else begin : g_mid
      assign upper[i] = q[i+1];
    end

    always_comb begin
      if (load)       nxt[i] = par_in[i];
      else if (shift) nxt[i] = upper[i];
      else            nxt[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/bitser_carry.sv
module bitser_carry
  import bitser_add_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic carry_q
);

  logic carry_nxt;

  assign sum_bit   = fa_sum(a_bit, b_bit, carry_q);
  assign carry_nxt = fa_carry(a_bit, b_bit, carry_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     carry_q <= 1'b0;
    else if (clear) carry_q <= 1'b0;
    else if (step)  carry_q <= carry_nxt;
  end

endmodule

// File: rtl/bitser_stepctr.sv
module bitser_stepctr #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic run_q,
  output logic last
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;

  assign last = (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) run_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bitser_add.sv
module bitser_add #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] a_load,
  input  logic [WIDTH-1:0] b_load,
  input  logic             b_ser_in,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] opb_o,
  output logic             ovf_o,
  output logic             busy_o,
  output logic             done_o
);

  logic step_w;
  logic last_w;
  logic sum_bit_w;
  logic carry_w;
  logic run_w;
  logic done_q;

  // one serial step: running, enabled, and not overridden by a load
  assign step_w = run_w & shift_en & ~start;

  bitser_stepctr #(.WIDTH(WIDTH)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .step  (step_w),
    .run_q (run_w),
    .last  (last_w)
  );

  bitser_carry u_cy (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .step    (step_w),
    .a_bit   (acc_o[0]),
    .b_bit   (opb_o[0]),
    .sum_bit (sum_bit_w),
    .carry_q (carry_w)
  );

  bitser_shreg #(.WIDTH(WIDTH)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .shift  (step_w),
    .par_in (a_load),
    .ser_in (sum_bit_w),
    .q      (acc_o)
  );

  bitser_shreg #(.WIDTH(WIDTH)) u_opb (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .shift  (step_w),
    .par_in (b_load),
    .ser_in (b_ser_in),
    .q      (opb_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= step_w & last_w;
  end

  assign ovf_o  = carry_w;
  assign busy_o = run_w;
  assign done_o = done_q;

endmodule

// File: rtl/bitser_add_chk.sv
module bitser_add_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             shift_en,
  input logic [WIDTH-1:0] a_load,
  input logic [WIDTH-1:0] b_load,
  input logic             b_ser_in,
  input logic [WIDTH-1:0] acc_o,
  input logic [WIDTH-1:0] opb_o,
  input logic             ovf_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             step_w,
  input logic             last_w
);

  // R2
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc_o == $past(a_load)) && (opb_o == $past(b_load)) && !ovf_o && busy_o);

  // R3
  a_r3_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (start && shift_en) |=> busy_o && !done_o);

  // R4
  a_r4_sum_msb: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> acc_o[WIDTH-1] == ($past(acc_o[0]) ^ $past(opb_o[0]) ^ $past(ovf_o)));

  // R5
  a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> ovf_o == (($past(acc_o[0]) & $past(opb_o[0])) |
                         ($past(acc_o[0]) & $past(ovf_o)) |
                         ($past(opb_o[0]) & $past(ovf_o))));

  // R6
  a_r6_ser_in: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> opb_o[WIDTH-1] == $past(b_ser_in));

  // R7
  a_r7_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r7_end: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && last_w) |=> done_o && !busy_o);

  // R9
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !shift_en && !start) |=> $stable(acc_o) && $stable(opb_o) && $stable(ovf_o) && busy_o);

  // R10
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start) |=> $stable(acc_o) && $stable(opb_o) && $stable(ovf_o) && !busy_o);

endmodule

bind bitser_add bitser_add_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .shift_en (shift_en),
  .a_load   (a_load),
  .b_load   (b_load),
  .b_ser_in (b_ser_in),
  .acc_o    (acc_o),
  .opb_o    (opb_o),
  .ovf_o    (ovf_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .step_w   (step_w),
  .last_w   (last_w)
);

// File: tb/bitser_add_test.sv
module bitser_add_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         shift_en = 1'b0;
  logic [W-1:0] a_load = '0;
  logic [W-1:0] b_load = '0;
  logic         b_ser_in = 1'b0;
  logic [W-1:0] acc_o;
  logic [W-1:0] opb_o;
  logic         ovf_o;
  logic         busy_o;
  logic         done_o;

  int total = 0;
  int bad   = 0;

  // behavioural reference state
  int m_a = 0;
  int m_b = 0;
  int m_c = 0;
  int m_n = 0;
  int m_busy = 0;
  int m_done = 0;

  always #5 clk = ~clk;

  bitser_add #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .shift_en(shift_en),
    .a_load(a_load), .b_load(b_load), .b_ser_in(b_ser_in),
    .acc_o(acc_o), .opb_o(opb_o), .ovf_o(ovf_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // advance model on a clock edge from the driven inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_c = 0; m_n = 0; m_busy = 0; m_done = 0;
    end else if (start) begin
      m_a = a_load; m_b = b_load; m_c = 0; m_n = 0; m_busy = 1; m_done = 0;
    end else if (m_busy == 1 && shift_en) begin
      int s;
      s = (m_a % 2) + (m_b % 2) + m_c;
      m_a = (m_a / 2) + (s % 2) * (1 << (W-1));
      m_b = (m_b / 2) + int'(b_ser_in) * (1 << (W-1));
      m_c = s / 2;
      m_n = m_n + 1;
      m_done = (m_n == W) ? 1 : 0;
      m_busy = (m_n == W) ? 0 : 1;
    end else begin
      m_done = 0;
    end
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 acc", int'(acc_o), m_a);
      check("R6 opb", int'(opb_o), m_b);
      check("R5 carry", int'(ovf_o), m_c);
      check("R7 busy", int'(busy_o), m_busy);
      check("R7 done", int'(done_o), m_done);
    end
  end

  task automatic tick(input logic st, input logic en, input logic ser);
    start = st; shift_en = en; b_ser_in = ser;
    @(negedge clk);
  endtask

  task automatic begin_add(input int a, input int b);
    a_load = W'(a); b_load = W'(b);
    tick(1'b1, 1'b0, 1'b0);
    check("R2 load a", int'(acc_o), a);
    check("R2 load b", int'(opb_o), b);
    check("R2 carry clear", int'(ovf_o), 0);
    check("R2 busy", int'(busy_o), 1);
  endtask

  task automatic run_full(input int a, input int b, input string tag);
    int sum;
    sum = a + b;
    begin_add(a, b);
    for (int i = 0; i < W; i++) tick(1'b0, 1'b1, 1'b0);
    check({tag, " R7 sum"}, int'(acc_o), sum % (1 << W));
    check({tag, " R8 ovf"}, int'(ovf_o), sum / (1 << W));
    check({tag, " R7 done pulse"}, int'(done_o), 1);
    tick(1'b0, 1'b0, 1'b0);
    check({tag, " R7 done drop"}, int'(done_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc", int'(acc_o), 0);
    check("R1 busy", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(acc_o) + int'(opb_o) + int'(ovf_o) + int'(done_o), 0);

    // R11 worked example: low bits 1,1,0,1 with carry 1 after step 3
    begin_add(4, 7);
    tick(1'b0, 1'b1, 1'b0); check("R11 bit0", int'(acc_o[W-1]), 1);
    tick(1'b0, 1'b1, 1'b0); check("R11 bit1", int'(acc_o[W-1]), 1);
    tick(1'b0, 1'b1, 1'b0); check("R11 bit2", int'(acc_o[W-1]), 0);
    check("R11 carry after bit2", int'(ovf_o), 1);
    tick(1'b0, 1'b1, 1'b0); check("R11 bit3", int'(acc_o[W-1]), 1);
    for (int i = 4; i < W; i++) tick(1'b0, 1'b1, 1'b0);
    check("R11 final acc", int'(acc_o), 11);
    check("R11 final carry", int'(ovf_o), 0);
    tick(1'b0, 1'b0, 1'b0);

    run_full(200, 100, "ovf");
    run_full(255, 1, "wrap");
    run_full(255, 255, "max");
    run_full(0, 0, "zero");
    run_full(85, 170, "alt");

    // R9 stalls with R6 streaming a new operand into B
    begin_add(19, 58);
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] hold_a;
      hold_a = acc_o;
      tick(1'b0, 1'b0, 1'b1);
      check("R9 stall acc", int'(acc_o), int'(hold_a));
      tick(1'b0, 1'b1, (8'hC5 >> i) & 1'b1);
    end
    check("R9 sum after stalls", int'(acc_o), 77);
    check("R6 streamed operand", int'(opb_o), 8'hC5);
    tick(1'b0, 1'b0, 1'b0);

    // R10 idle shift_en has no effect
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b1);
    check("R10 idle acc", int'(acc_o), 77);
    check("R10 idle opb", int'(opb_o), 8'hC5);
    check("R10 idle busy", int'(busy_o), 0);

    // R3 start mid-run with shift_en high restarts and takes no step
    begin_add(10, 20);
    tick(1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b1, 1'b0);
    a_load = 8'd90; b_load = 8'd9;
    tick(1'b1, 1'b1, 1'b1);
    check("R3 reload acc", int'(acc_o), 90);
    check("R3 reload opb", int'(opb_o), 9);
    check("R3 carry clear", int'(ovf_o), 0);
    for (int i = 0; i < W; i++) tick(1'b0, 1'b1, 1'b0);
    check("R3 full count after restart", int'(acc_o), 99);
    check("R3 done", int'(done_o), 1);
    tick(1'b0, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule